// File: doc/BRIEF.md
# Bus Clock Divider Factor Search

This block finds the pair of bus clock divider settings, a 3-bit exponent N and a 4-bit multiplier M, that best approaches a requested serial bus frequency from a given input clock frequency. A pulse on `start_i` captures both 32-bit frequencies. The engine then steps through every divider pair in a fixed order and computes each pair's resulting bus frequency with a multi-cycle shift-and-subtract divider. It keeps the pair whose frequency is closest to the request without going above it.

When the search ends, the chosen pair and a found flag are presented, and `done_o` pulses for one cycle. The results stay on the outputs until the next accepted start. An exact match ends the search early. The engine works out the setting once, at configuration time. Writing the chosen values into a bus controller is left to the surrounding logic.

Top module: `baud_factor_search`

## Requirements
- R1: The frequency of a pair is floor(tclk / (10 * (M+1) * 2^(N+1))), computed in unsigned 32-bit integer arithmetic.
- R2: Pairs are visited with N as the outer loop from 0 to 7 and M as the inner loop from 0 to 15. Among pairs with equal difference, the one visited first is reported.
- R3: A pair is eligible only when its frequency is not above the request. The reported pair has the smallest value of (request − frequency) among the eligible pairs.
- R4: The search stops right after the first pair whose difference is zero. When pair (N=0, M=0) matches exactly, `done_o` rises within 40 cycles of the start pulse.
- R5: When no pair is eligible, `found_o` is 0 and `n_o` and `m_o` are 0. Otherwise `found_o` is 1.
- R6: `done_o` is high for exactly one cycle per accepted search. `n_o`, `m_o` and `found_o` change only in the cycle where `done_o` is high.
- R7: A start pulse that arrives during a search is ignored. The running search completes with the frequencies captured at its own start, and it produces exactly one done pulse.
- R8: A zero input clock frequency gives a frequency of 0 for every pair. The search still finishes, and it reports found with N=0 and M=0.
- R9: After reset, `done_o`, `found_o`, `n_o` and `m_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| tclk_i | input | 32 | Input clock frequency, unsigned |
| req_i | input | 32 | Requested bus frequency, unsigned |
| n_o | output | 3 | Selected exponent N |
| m_o | output | 4 | Selected multiplier M |
| found_o | output | 1 | An eligible pair was found |
| done_o | output | 1 | One-cycle pulse at the end of a search |

## Verification
The search is driven with random clock and request pairs, where the request is drawn either freely or from the range below tclk/20. This mix produces searches that run all 128 pairs as well as searches that match exactly and stop early. Directed cases separate the remaining behaviours:
- a request of zero with a large input clock, where no pair is eligible;
- a request of zero with a small input clock, where many pairs truncate to zero and the tie rule picks the first one;
- a zero input clock;
- full-scale operands;
- an exact match at the first pair, which checks early stopping through latency;
- a start pulse with changed inputs during a search, which must leave that search's result untouched.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT
    } search_state_e;

endpackage

// File: rtl/baud_div.sv
module baud_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         valid_o,
    output logic [W-1:0] quot_o
);
    localparam int CNT_W = $clog2(W) + 1;

    typedef struct packed {
        logic             busy;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     dvd;
        logic [W-1:0]     dvd_ref;
        logic [W-1:0]     dvs;
        logic [W:0]       rem;
        logic [W-1:0]     quot;
    } div_st_t;

    div_st_t d, q;
    logic [W:0] trial;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        trial   = {q.rem[W-1:0], q.dvd[W-1]};
        if (go_i) begin
            d.dvd_ref = dvd_i;
            d.quot    = '0;
            if (dvs_i == '0) begin
                // a zero divisor must not stall the search: report zero at once
                d.busy  = 1'b0;
                d.valid = 1'b1;
            end else begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.dvd  = dvd_i;
                d.dvs  = dvs_i;
                d.rem  = '0;
            end
        end else if (q.busy) begin
            d.dvd = {q.dvd[W-2:0], 1'b0};
            if (trial >= {1'b0, q.dvs}) begin
                d.rem  = trial - {1'b0, q.dvs};
                d.quot = {q.quot[W-2:0], 1'b1};
            end else begin
                d.rem  = trial;
                d.quot = {q.quot[W-2:0], 1'b0};
            end
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(W - 1)) begin
                d.busy  = 1'b0;
                d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o = q.valid;
    assign quot_o  = q.quot;

    // R1
    quot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> (q.quot <= q.dvd_ref));

endmodule

// File: rtl/baud_divisor_gen.sv
module baud_divisor_gen #(
    parameter int FREQ_W = 32,
    parameter int N_W    = 3,
    parameter int M_W    = 4,
    parameter int SCALE  = 10
) (
    input  logic [N_W-1:0]    n_i,
    input  logic [M_W-1:0]    m_i,
    output logic [FREQ_W-1:0] dvs_o
);
    logic [FREQ_W-1:0] base;

    always_comb begin
        base  = FREQ_W'(SCALE) * (FREQ_W'(m_i) + FREQ_W'(1));
        dvs_o = base << (FREQ_W'(n_i) + FREQ_W'(1));
    end

endmodule

// File: rtl/baud_factor_search.sv
module baud_factor_search
    import baud_search_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int N_W    = 3,
    parameter int M_W    = 4,
    parameter int SCALE  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] tclk_i,
    input  logic [FREQ_W-1:0] req_i,
    output logic [N_W-1:0]    n_o,
    output logic [M_W-1:0]    m_o,
    output logic              found_o,
    output logic              done_o
);
    localparam logic [N_W-1:0] N_LAST = {N_W{1'b1}};
    localparam logic [M_W-1:0] M_LAST = {M_W{1'b1}};

    typedef struct packed {
        search_state_e     state;
        logic [FREQ_W-1:0] tclk;
        logic [FREQ_W-1:0] req;
        logic [N_W-1:0]    n;
        logic [M_W-1:0]    m;
        logic [N_W-1:0]    best_n;
        logic [M_W-1:0]    best_m;
        logic [FREQ_W-1:0] best_diff;
        logic              have_best;
        logic              go;
        logic [N_W-1:0]    out_n;
        logic [M_W-1:0]    out_m;
        logic              out_found;
        logic              done;
    } top_st_t;

    top_st_t d, q;

    logic [FREQ_W-1:0] dvs;
    logic              div_valid;
    logic [FREQ_W-1:0] div_quot;
    logic              eligible;
    logic              better;
    logic [FREQ_W-1:0] diff;

    baud_divisor_gen #(
        .FREQ_W (FREQ_W),
        .N_W    (N_W),
        .M_W    (M_W),
        .SCALE  (SCALE)
    ) i_divisor_gen (
        .n_i   (q.n),
        .m_i   (q.m),
        .dvs_o (dvs)
    );

    baud_div #(
        .W (FREQ_W)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (q.go),
        .dvd_i   (q.tclk),
        .dvs_i   (dvs),
        .valid_o (div_valid),
        .quot_o  (div_quot)
    );

    always_comb begin
        d        = q;
        d.go     = 1'b0;
        d.done   = 1'b0;
        eligible = (q.req >= div_quot);
        diff     = q.req - div_quot;
        better   = eligible && (!q.have_best || (diff < q.best_diff));
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.tclk      = tclk_i;
                    d.req       = req_i;
                    d.n         = '0;
                    d.m         = '0;
                    d.have_best = 1'b0;
                    d.best_diff = '1;
                    d.best_n    = '0;
                    d.best_m    = '0;
                    d.state     = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                d.go    = 1'b1;
                d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_valid) begin
                    if (better) begin
                        d.best_n    = q.n;
                        d.best_m    = q.m;
                        d.best_diff = diff;
                        d.have_best = 1'b1;
                    end
                    if ((better && (diff == '0)) || ((q.n == N_LAST) && (q.m == M_LAST))) begin
                        d.out_found = d.have_best;
                        d.out_n     = d.have_best ? d.best_n : '0;
                        d.out_m     = d.have_best ? d.best_m : '0;
                        d.done      = 1'b1;
                        d.state     = ST_IDLE;
                    end else begin
                        if (q.m == M_LAST) begin
                            d.m = '0;
                            d.n = q.n + 1'b1;
                        end else begin
                            d.m = q.m + 1'b1;
                        end
                        d.state = ST_LAUNCH;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign n_o     = q.out_n;
    assign m_o     = q.out_m;
    assign found_o = q.out_found;
    assign done_o  = q.done;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(n_o) && $stable(m_o) && $stable(found_o)));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state != ST_IDLE) && start_i) |=> ($stable(q.tclk) && $stable(q.req)));

    // R5
    notfound_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> ((n_o == '0) && (m_o == '0)));

endmodule

// File: tb/test_baud_factor_search.sv
module test_baud_factor_search;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] tclk_i = '0;
    logic [31:0] req_i = '0;
    logic [2:0]  n_o;
    logic [3:0]  m_o;
    logic        found_o;
    logic        done_o;

    int tests = 0;
    int fails = 0;
    int done_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_factor_search i_baud_factor_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .tclk_i  (tclk_i),
        .req_i   (req_i),
        .n_o     (n_o),
        .m_o     (m_o),
        .found_o (found_o),
        .done_o  (done_o)
    );

    always @(posedge clk) if (done_o) done_count <= done_count + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference model written from R1, R2, R3, R4 and R5
    function automatic void model(input logic [31:0] tclk, input logic [31:0] req,
                                  output logic [2:0] en, output logic [3:0] em,
                                  output logic ef);
        logic [63:0] best;
        logic        have;
        logic [63:0] f;
        logic        stop;
        en = '0; em = '0; have = 1'b0; best = '1; stop = 1'b0;
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 16; m++) begin
                if (!stop) begin
                    f = 64'(tclk) / (64'(10 * (m + 1)) << (n + 1));
                    if ((64'(req) >= f) && (!have || ((64'(req) - f) < best))) begin
                        best = 64'(req) - f;
                        have = 1'b1;
                        en = 3'(n);
                        em = 4'(m);
                    end
                    if (have && best == 0) stop = 1'b1;
                end
            end
        end
        ef = have;
    endfunction

    task automatic pulse_start(input logic [31:0] t, input logic [31:0] r);
        @(negedge clk);
        tclk_i  = t;
        req_i   = r;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done_o) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_search(input logic [31:0] t, input logic [31:0] r,
                              input string tag, output int lat);
        logic [2:0] en;
        logic [3:0] em;
        logic       ef;
        logic [2:0] hn;
        logic [3:0] hm;
        logic       hf;
        model(t, r, en, em, ef);
        pulse_start(t, r);
        wait_done(lat);
        check({tag, " R2 R3 n"}, 32'(n_o), 32'(en));
        check({tag, " R2 R3 m"}, 32'(m_o), 32'(em));
        check({tag, " R5 found"}, 32'(found_o), 32'(ef));
        hn = n_o; hm = m_o; hf = found_o;
        @(negedge clk);
        check({tag, " R6 done width"}, 32'(done_o), 32'd0);
        repeat (4) @(negedge clk);
        check({tag, " R6 hold"}, {25'd0, hf, hm, hn}, {25'd0, found_o, m_o, n_o});
    endtask

    initial begin
        int lat;
        int dc;
        logic [31:0] t;
        logic [31:0] r;
        logic [2:0] en;
        logic [3:0] em;
        logic       ef;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 done", 32'(done_o), 32'd0);
        check("R9 found", 32'(found_o), 32'd0);
        check("R9 n m", {25'd0, m_o, n_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 typical setting
        run_search(32'd100_000_000, 32'd100_000, "R1 typical", lat);
        // R5 nothing eligible: smallest frequency 1e6/40960 = 24 > 0
        run_search(32'd1_000_000, 32'd0, "R5 none", lat);
        check("R5 found low", 32'(found_o), 32'd0);
        // R2 ties: many pairs truncate to zero, first such pair wins
        run_search(32'd1000, 32'd0, "R2 ties", lat);
        // R8 zero input clock
        run_search(32'd0, 32'd5, "R8 zero tclk", lat);
        check("R8 pair", {24'd0, found_o, m_o, n_o}, 32'h80);
        // full-scale operands
        run_search(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 fullscale", lat);
        // R4 exact match at pair (0,0): 2000/20 = 100
        run_search(32'd2000, 32'd100, "R4 exact", lat);
        tests++;
        if (lat > 40) begin
            fails++;
            $display("FAIL R4 latency actual=%0d expected<=40", lat);
        end

        // R7 start during a search is ignored
        model(32'd50_000_000, 32'd400_000, en, em, ef);
        dc = done_count;
        pulse_start(32'd50_000_000, 32'd400_000);
        repeat (100) @(negedge clk);
        pulse_start(32'd3000, 32'd7);
        wait_done(lat);
        check("R7 n", 32'(n_o), 32'(en));
        check("R7 m", 32'(m_o), 32'(em));
        check("R7 found", 32'(found_o), 32'(ef));
        repeat (3) @(negedge clk);
        check("R7 single done", 32'(done_count - dc), 32'd1);

        // random mix
        for (int i = 0; i < 16; i++) begin
            t = $urandom();
            if (i % 2 == 0) r = $urandom();
            else r = $urandom() % (t / 20 + 1);
            run_search(t, r, "R3 random", lat);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog R4 actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule